// File: doc/BRIEF.md
# Receive Character Buffer with Status Tagging

This block sits behind the bit deserializer of an asynchronous serial receiver. Each arriving character comes with parity-error, framing-error and break flags. The block matches the character against four programmable special characters and an inclusive value range. It then stores the data byte together with a status byte in a buffer. The buffer holds twelve queued entries plus one holding entry, thirteen in all.

A host services the buffer with a service-acknowledge handshake. `svc_req` shows that something is waiting, and `ack` is held high for the acknowledge cycle. While `ack` is high, the head entry and a 3-bit interrupt-type code can be read. When `ack` falls, the head entry is removed, whether or not the host looked at it. If the buffer stays empty for a programmable number of bit-time ticks after the last entry was removed, the block raises a receive timeout. The timeout is reported through the same handshake.

Top module: `rx_status_fifo`

## Requirements
- R1: Stored characters are presented on `head_data` in arrival order. Up to 13 entries are kept (12 queued plus one holding). While the buffer is empty, `head_data` reads 0.
- R2: The status byte places the fields as follows: bit 7 is timeout, bits 6:4 are the match code, bit 3 is break, bit 2 is parity error, bit 1 is framing error and bit 0 is overrun.
- R3: The match code takes these values:
  - 000: no match.
  - 001 to 100: special characters 1 to 4. Special character k is `spc_chars[8k-1:8k-8]`, and when several match, the lowest index wins.
  - 110: end of break.
  - 111: the data lies within `range_lo..range_hi` inclusive and no special character matched.
  - 101: never produced.
- R4: A character with a parity or framing error gets match code 000, unless `match_on_err` is 1.
- R5: A character that arrives while all 13 entries are occupied, with no pop in that cycle, is discarded. Bit 0 is then set in the newest stored entry, and that entry's data stays unchanged.
- R6: Each falling edge of `ack` while the buffer holds an entry removes the head entry. No read is needed for this.
- R7: Arming the timeout:
  - When a pop empties the buffer, `tmo_en` is 1 and `tmo_reload` is N (not 0), a countdown starts.
  - After N `tick` pulses with no new character, the timeout flag is set.
  - While the flag is set and the buffer is empty, `svc_req` is 1 and `head_status` reads 8'h80.
  - A falling edge of `ack` or any arriving character clears the flag.
  - When `tmo_reload` is 0, no timeout occurs.
- R8: `ivec` is 000 while `ack` is low, and otherwise takes these values:
  - 010: the head entry has status 0.
  - 011: the head entry has a nonzero status, or the buffer is empty with a pending timeout.
  - 000: nothing is pending.
  - 001: never produced.
- R9: A break is stored with data byte 0 and bit 3 set. The next non-break character gets match code 110 when matching is allowed for it, and any non-break character ends the pending end-of-break state.
- R10: Reset empties the buffer, clears the timeout and end-of-break state, and drives `svc_req` 0, `head_status` 0 and `ivec` 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One-cycle strobe for an arriving character |
| in_data | input | 8 | Arriving character |
| in_perr | input | 1 | Parity error flag of the character |
| in_ferr | input | 1 | Framing error flag of the character |
| in_brk | input | 1 | Character is a break |
| spc_chars | input | 32 | Four special characters, character k in bits 8k-1:8k-8 |
| range_lo | input | 8 | Lower bound of the range match |
| range_hi | input | 8 | Upper bound of the range match |
| match_on_err | input | 1 | Allow matching on characters with errors |
| tmo_en | input | 1 | Enable timeout reporting |
| tmo_reload | input | 8 | Timeout period in ticks, 0 disables |
| tick | input | 1 | Bit-time tick |
| ack | input | 1 | Service acknowledge, pop on falling edge |
| svc_req | output | 1 | Entry or timeout pending |
| ivec | output | 3 | Interrupt-type code during acknowledge |
| head_status | output | 8 | Status byte of the head entry |
| head_data | output | 8 | Data byte of the head entry |

## Verification
The tests send several kinds of characters:
- Plain characters, which show that ordering works and that status stays clean.
- Characters that hit one special slot, that fall in the range, and that do both, which expose the match priority.
- The same special character with parity and framing errors, tried with the error-match enable off and then on, which shows that matching is suppressed only on errored characters.
- A break followed by a clean character, an errored character and a second clean character, which shows when the end-of-break code is given and when it is withdrawn.
- A burst of fourteen characters, which shows that the fourteenth is dropped and that the overrun mark lands on entry thirteen.

The timeout is tried three ways: with silence, with a character arriving mid-countdown, and with a zero reload. These tell a correct countdown apart from one that misses cancellation or misses the disable.

// File: rtl/rx_status_fifo.sv
module rx_status_fifo #(
  parameter int DEPTH = 12,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_perr,
  input  logic          in_ferr,
  input  logic          in_brk,
  input  logic [31:0]   spc_chars,
  input  logic [7:0]    range_lo,
  input  logic [7:0]    range_hi,
  input  logic          match_on_err,
  input  logic          tmo_en,
  input  logic [TW-1:0] tmo_reload,
  input  logic          tick,
  input  logic          ack,
  output logic          svc_req,
  output logic [2:0]    ivec,
  output logic [7:0]    head_status,
  output logic [7:0]    head_data
);
  localparam int CAP = DEPTH + 1;
  localparam int AW = $clog2(CAP);
  localparam int CW = $clog2(CAP + 1);

  logic [15:0]   mem [CAP];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          ack_q, eob_pend, armed, tmo_flag;
  logic [TW-1:0] tmo_cnt;
  logic [2:0]    hit;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(CAP - 1)) ? '0 : p + AW'(1);
  endfunction

  wire          empty    = (count == '0);
  wire          ack_end  = ack_q && !ack;
  wire          pop      = ack_end && !empty;
  wire          room     = (count != CW'(CAP)) || pop;
  wire          wr       = in_valid && room;
  wire          allow    = !(in_perr || in_ferr) || match_on_err;
  wire [AW-1:0] last_ptr = (wr_ptr == '0) ? AW'(CAP - 1) : wr_ptr - AW'(1);

  always_comb begin
    hit = 3'b000;
    if (in_data >= range_lo && in_data <= range_hi) hit = 3'b111;
    for (int k = 3; k >= 0; k--)
      if (in_data == spc_chars[8*k +: 8]) hit = 3'(k + 1);
  end

  wire [2:0] code     = (in_brk || !allow) ? 3'b000 : (eob_pend ? 3'b110 : hit);
  wire [7:0] new_stat = {1'b0, code, in_brk, in_perr, in_ferr, 1'b0};
  wire [7:0] new_data = in_brk ? 8'h00 : in_data;

  always_ff @(posedge clk) begin
    if (wr) mem[wr_ptr] <= {new_stat, new_data};
    else if (in_valid) mem[last_ptr][8] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      count    <= '0;
      ack_q    <= 1'b0;
      eob_pend <= 1'b0;
      armed    <= 1'b0;
      tmo_flag <= 1'b0;
      tmo_cnt  <= '0;
    end else begin
      ack_q <= ack;
      if (pop) rd_ptr <= nxt(rd_ptr);
      if (wr) wr_ptr <= nxt(wr_ptr);
      count <= count + CW'(wr) - CW'(pop);
      if (in_valid) eob_pend <= in_brk;
      if (in_valid) begin
        armed    <= 1'b0;
        tmo_flag <= 1'b0;
      end else begin
        if (ack_end && empty) tmo_flag <= 1'b0;
        if (pop && count == CW'(1) && tmo_en && tmo_reload != '0) begin
          armed   <= 1'b1;
          tmo_cnt <= tmo_reload;
        end else if (armed && tick) begin
          if (!tmo_en) armed <= 1'b0;
          else if (tmo_cnt == TW'(1)) begin
            armed    <= 1'b0;
            tmo_flag <= 1'b1;
          end else tmo_cnt <= tmo_cnt - TW'(1);
        end
      end
    end
  end

  wire [15:0] head = mem[rd_ptr];
  assign svc_req     = !empty || tmo_flag;
  assign head_status = empty ? {tmo_flag, 7'b0} : head[15:8];
  assign head_data   = empty ? 8'h00 : head[7:0];
  assign ivec = !ack ? 3'b000 :
                empty ? (tmo_flag ? 3'b011 : 3'b000) :
                (head[15:8] != 8'h00 ? 3'b011 : 3'b010);

  // R8
  no_invalid_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ivec != 3'b001);
  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(CAP));
  // R3
  no_unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> head_status[6:4] != 3'b101);
  // R6
  ack_pops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && !ack && !empty && !in_valid) |=> count == $past(count) - CW'(1));
  // R5
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && count == CW'(CAP) && !(ack_q && !ack)) |=> count == CW'(CAP));
  // R7
  tmo_only_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && head_status[7]) |-> svc_req);
endmodule

// File: tb/rx_status_fifo_test.sv
module rx_status_fifo_test;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_perr = 0, in_ferr = 0, in_brk = 0;
  logic [7:0] in_data = 0, range_lo = 8'h30, range_hi = 8'h39;
  logic [31:0] spc_chars = {8'h44, 8'h43, 8'h42, 8'h41};
  logic match_on_err = 0, tmo_en = 0, tick = 0, ack = 0;
  logic [7:0] tmo_reload = 0;
  logic svc_req;
  logic [2:0] ivec;
  logic [7:0] head_status, head_data;
  int total = 0, fails = 0;

  rx_status_fifo uut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  logic [15:0] q[$];
  bit m_ackq, m_eob, m_arm, m_flag;
  int m_cnt;

  function automatic logic [2:0] mcode(input logic [7:0] d);
    for (int k = 0; k < 4; k++) if (d == spc_chars[8*k +: 8]) return 3'(k + 1);
    if (d >= range_lo && d <= range_hi) return 3'b111;
    return 3'b000;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_ackq = 0; m_eob = 0; m_arm = 0; m_flag = 0; m_cnt = 0;
    end else begin
      bit ae, pe, emp;
      int sz;
      logic [2:0] c;
      ae = m_ackq && !ack; sz = q.size(); emp = (sz == 0); pe = ae && !emp;
      if (pe) void'(q.pop_front());
      if (in_valid) begin
        if (in_brk || ((in_perr || in_ferr) && !match_on_err)) c = 0;
        else if (m_eob) c = 3'b110;
        else c = mcode(in_data);
        if (q.size() < 13)
          q.push_back({1'b0, c, in_brk, in_perr, in_ferr, 1'b0, in_brk ? 8'h00 : in_data});
        else q[q.size()-1][8] = 1'b1;
        m_eob = in_brk;
        m_arm = 0; m_flag = 0;
      end else begin
        if (ae && emp) m_flag = 0;
        if (pe && sz == 1 && tmo_en && tmo_reload != 0) begin
          m_arm = 1; m_cnt = tmo_reload;
        end else if (m_arm && tick) begin
          if (!tmo_en) m_arm = 0;
          else if (m_cnt == 1) begin m_arm = 0; m_flag = 1; end
          else m_cnt--;
        end
      end
      m_ackq = ack;
    end
  end

  initial forever begin
    @(posedge clk); #1;
    if (rst_n) begin
      logic [7:0] es;
      es = q.size() ? q[0][15:8] : {m_flag, 7'b0};
      chk("R7 svc_req", svc_req, (q.size() > 0) || m_flag);
      chk("R2 head_status", head_status, es);
      chk("R1 head_data", head_data, q.size() ? q[0][7:0] : 0);
      chk("R8 ivec", ivec, !ack ? 0 : q.size() == 0 ? (m_flag ? 3 : 0) : (es != 0 ? 3 : 2));
    end
  end

  initial forever begin
    repeat (3) @(negedge clk);
    tick = 1;
    @(negedge clk);
    tick = 0;
  end

  task automatic send(input logic [7:0] d, input bit p = 0, input bit f = 0, input bit b = 0);
    @(negedge clk);
    in_valid = 1; in_data = d; in_perr = p; in_ferr = f; in_brk = b;
    @(negedge clk);
    in_valid = 0; in_perr = 0; in_ferr = 0; in_brk = 0;
  endtask

  task automatic expect_head(input string tag, input int st, input int d);
    @(negedge clk);
    chk({tag, " status"}, head_status, st);
    chk({tag, " data"}, head_data, d);
  endtask

  task automatic pop_one(input string tag, input int exp_ivec);
    @(negedge clk);
    ack = 1;
    @(negedge clk);
    chk({tag, " ivec"}, ivec, exp_ivec);
    ack = 0;
    @(negedge clk);
  endtask

  task automatic one(input string tag, input logic [7:0] d, input bit p, input bit f,
                     input bit b, input int st, input int dd);
    send(d, p, f, b);
    expect_head(tag, st, dd);
    pop_one(tag, st != 0 ? 3 : 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 svc_req in reset", svc_req, 0);
    chk("R10 ivec in reset", ivec, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R10 svc_req after reset", svc_req, 0);
    chk("R10 status after reset", head_status, 0);

    one("R3 special 2", 8'h42, 0, 0, 0, 8'h20, 8'h42);
    one("R3 range", 8'h35, 0, 0, 0, 8'h70, 8'h35);
    one("R3 no match", 8'h7A, 0, 0, 0, 8'h00, 8'h7A);
    one("R3 special 4", 8'h44, 0, 0, 0, 8'h40, 8'h44);
    spc_chars[31:24] = 8'h35;
    spc_chars[23:16] = 8'h41;
    one("R3 special beats range", 8'h35, 0, 0, 0, 8'h40, 8'h35);
    one("R3 lowest index wins", 8'h41, 0, 0, 0, 8'h10, 8'h41);
    spc_chars = {8'h44, 8'h43, 8'h42, 8'h41};

    one("R4 parity no match", 8'h41, 1, 0, 0, 8'h04, 8'h41);
    one("R4 framing no match", 8'h35, 0, 1, 0, 8'h02, 8'h35);
    match_on_err = 1;
    one("R4 framing with match", 8'h41, 0, 1, 0, 8'h12, 8'h41);
    match_on_err = 0;

    one("R9 break entry", 8'h55, 0, 0, 1, 8'h08, 8'h00);
    one("R9 end of break", 8'h41, 0, 0, 0, 8'h60, 8'h41);
    one("R9 after end of break", 8'h41, 0, 0, 0, 8'h10, 8'h41);
    one("R9 break again", 8'h00, 0, 0, 1, 8'h08, 8'h00);
    one("R9 errored after break", 8'h41, 1, 0, 0, 8'h04, 8'h41);
    one("R9 eob withdrawn", 8'h41, 0, 0, 0, 8'h10, 8'h41);

    for (int i = 0; i < 14; i++) send(8'h61 + 8'(i));
    for (int i = 0; i < 13; i++) begin
      expect_head("R5 R6 drain", i == 12 ? 8'h01 : 8'h00, 8'h61 + i);
      pop_one("R6 pop", i == 12 ? 3 : 2);
    end
    @(negedge clk);
    chk("R5 dropped char absent", svc_req, 0);

    tmo_en = 1; tmo_reload = 3;
    send(8'h7A);
    pop_one("R7 arm", 2);
    repeat (20) @(negedge clk);
    chk("R7 timeout pending", svc_req, 1);
    chk("R7 timeout status", head_status, 8'h80);
    pop_one("R7 timeout ack", 3);
    chk("R7 timeout cleared", svc_req, 0);

    send(8'h7A);
    pop_one("R7 rearm", 2);
    repeat (2) @(negedge clk);
    send(8'h7B);
    repeat (20) @(negedge clk);
    chk("R7 arrival cancels", head_status, 8'h00);
    pop_one("R7 pop char", 2);
    repeat (20) @(negedge clk);
    chk("R7 timeout after second", head_status, 8'h80);
    pop_one("R7 ack second", 3);

    tmo_reload = 0;
    send(8'h7A);
    pop_one("R7 zero reload", 2);
    repeat (30) @(negedge clk);
    chk("R7 zero reload no timeout", svc_req, 0);
    pop_one("R8 idle ack", 0);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1_000_000;
    total++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule